// File: doc/BRIEF.md
# Masked Misc Register with Alias Ports and Interrupt

This block holds one 64-bit status/control word on a simple register bus that addresses whole doublewords. Three neighbouring word offsets all reach the same storage. One offset reads and overwrites the register directly. A second offset combines the write data with the stored value. A third offset ORs the write data into it. Only the top 16 bits of the register are kept, and the most significant bit is driven out as a level interrupt.

The parameter `MODE` selects the variant of the combining alias and, with it, the base offset. With `MODE = 0` the aliases sit at word offsets 0x4020 (direct), 0x4021 (AND) and 0x4022 (OR). With `MODE = 1` they sit at 0x6080 (direct), 0x6081 (clear-all) and 0x6082 (OR). Software uses the OR alias to raise flags and the combining alias to drop them, without a read-modify-write sequence.

Every bus access is a full 8-byte doubleword. The word offset is the byte address shifted right by three.

Top module: `misc_alias_reg`

## Requirements
- R1: The word offset is `req_addr >> 3`. The three low byte-address bits never change which alias is selected.
- R2: With MODE 0 the direct, AND and OR aliases are at word offsets 0x4020, 0x4021 and 0x4022. With MODE 1 the direct, clear and OR aliases are at 0x6080, 0x6081 and 0x6082.
- R3: Every update keeps only bits 63:48 of the new value. Bits 47:0 of the register always read as zero.
- R4: In MODE 0, a write to the AND alias stores (current AND write data), masked as in R3.
- R5: A write to the OR alias stores (current OR write data), masked as in R3.
- R6: In MODE 1, a write to the clear alias sets the register to zero whatever the write data is.
- R7: A direct write stores the masked write data.
- R8: `irq_out` equals bit 63 of the stored value. It changes on the clock edge that captures the write.
- R9: Writes to any other offset leave the register unchanged. Reads of any other offset return zero.
- R10: Synchronous reset clears the register, so `irq_out` is low after reset.
- R11: `rsp_valid` is high for exactly the cycle after each read strobe. `rsp_rdata` holds the value as it was before any write accepted in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Write strobe, one cycle per write |
| req_rd | input | 1 | Read strobe, one cycle per read |
| req_addr | input | ADDR_W | Byte address of the doubleword |
| req_wdata | input | DATA_W | Write data, bit 63 is the most significant |
| rsp_valid | output | 1 | Read data valid, one cycle after `req_rd` |
| rsp_rdata | output | DATA_W | Read data |
| irq_out | output | 1 | Level interrupt, equal to stored bit 63 |

## Verification
The bench drives one bus into two instances, one per mode, so that every write aimed at one mode's offsets is also a stray write for the other. A decoder that ignored `MODE` would then change both registers. AND writes are given data with bit 63 cleared, so a design that ORed, or failed to drop the interrupt, reports a stale `irq_out`. A clear write carries all-ones data and a later one carries zero data, which exposes a clear alias that depends on its data. Other checks target a direct write with low-half garbage (a missing mask), byte addresses with nonzero low bits (a decoder that does not shift), a read in the same cycle as a write (it must return the old value), and a read of an alias offset (it must return zero, not the register).

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_CLEAR = 3'd4
  } op_e;

  localparam int MODE_AND   = 0;
  localparam int MODE_CLEAR = 1;

  function automatic logic [31:0] base_word(input int mode);
    return (mode == MODE_CLEAR) ? 32'h0000_6080 : 32'h0000_4020;
  endfunction
endpackage

// File: rtl/misc_alias_decode.sv
module misc_alias_decode
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MODE   = MODE_AND
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output op_e               wr_op,
  output logic              rd_hit
);
  localparam int WORD_W = ADDR_W - 3;
  localparam logic [WORD_W-1:0] BASE = WORD_W'(base_word(MODE));

  logic [WORD_W-1:0] word;
  op_e               comb_op;

  assign word = WORD_W'(addr >> 3);

  generate
    if (MODE == MODE_CLEAR) begin : g_clear
      assign comb_op = OP_CLEAR;
    end else begin : g_and
      assign comb_op = OP_AND;
    end
  endgenerate

  always_comb begin
    wr_op = OP_NONE;
    if (wr) begin
      if (word == BASE)                   wr_op = OP_LOAD;
      else if (word == BASE + WORD_W'(1)) wr_op = comb_op;
      else if (word == BASE + WORD_W'(2)) wr_op = OP_OR;
    end
  end

  assign rd_hit = rd && (word == BASE);
endmodule

// File: rtl/misc_alias_update.sv
module misc_alias_update
  import misc_alias_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] nxt
);
  localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {(DATA_W-KEEP_W){1'b0}}};

  always_comb begin
    case (op)
      OP_LOAD:  nxt = wdata & KEEP_MASK;
      OP_AND:   nxt = (cur & wdata) & KEEP_MASK;
      OP_OR:    nxt = (cur | wdata) & KEEP_MASK;
      OP_CLEAR: nxt = '0;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/misc_alias_rdport.sv
module misc_alias_rdport #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] cur,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd_hit ? cur : '0;
    end
  end
endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16,
  parameter int MODE   = MODE_AND
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_out
);
  op_e               wr_op;
  logic              rd_hit;
  logic [DATA_W-1:0] store_q;
  logic [DATA_W-1:0] store_nxt;

  misc_alias_decode #(.ADDR_W(ADDR_W), .MODE(MODE)) u_decode (
    .wr     (req_wr),
    .rd     (req_rd),
    .addr   (req_addr),
    .wr_op  (wr_op),
    .rd_hit (rd_hit)
  );

  misc_alias_update #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_update (
    .op    (wr_op),
    .cur   (store_q),
    .wdata (req_wdata),
    .nxt   (store_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      irq_out <= 1'b0;
    end else begin
      store_q <= store_nxt;
      irq_out <= store_nxt[DATA_W-1];
    end
  end

  misc_alias_rdport #(.DATA_W(DATA_W)) u_rdport (
    .clk       (clk),
    .rst       (rst),
    .rd        (req_rd),
    .rd_hit    (rd_hit),
    .cur       (store_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/misc_alias_reg_chk.sv
module misc_alias_reg_chk
  import misc_alias_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_rd,
  input logic [DATA_W-1:0] req_wdata,
  input op_e               wr_op,
  input logic              rd_hit,
  input logic [DATA_W-1:0] store_q,
  input logic              irq_out,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {(DATA_W-KEEP_W){1'b0}}};

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (store_q & ~KEEP_MASK) == '0);

  a_r3_read_low_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata & ~KEEP_MASK) == '0);

  a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
    (wr_op == OP_CLEAR) |=> store_q == '0);

  a_r7_direct_load: assert property (@(posedge clk) disable iff (rst)
    (wr_op == OP_LOAD) |=> store_q == $past(req_wdata & KEEP_MASK));

  a_r8_irq_tracks_msb: assert property (@(posedge clk) disable iff (rst)
    irq_out == store_q[DATA_W-1]);

  a_r9_stray_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_op == OP_NONE) |=> $stable(store_q));

  a_r9_miss_read_zero: assert property (@(posedge clk) disable iff (rst)
    (req_rd && !rd_hit) |=> rsp_rdata == '0);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (store_q == '0 && !irq_out && !rsp_valid));

  a_r11_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rsp_valid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !req_rd |=> !rsp_valid);
endmodule

bind misc_alias_reg misc_alias_reg_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_rd    (req_rd),
  .req_wdata (req_wdata),
  .wr_op     (wr_op),
  .rd_hit    (rd_hit),
  .store_q   (store_q),
  .irq_out   (irq_out),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata)
);

// File: tb/misc_alias_reg_bench.sv
`timescale 1ns/1ps
module misc_alias_reg_bench;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int NVEC   = 12;

  // stimulus: word offset, write data; expected upper 16 bits for each mode
  localparam logic [31:0] V_WORD [NVEC] = '{
    32'h4020, 32'h4022, 32'h4021, 32'h6080, 32'h6082, 32'h6081,
    32'h6080, 32'h4023, 32'h4021, 32'h6082, 32'h4022, 32'h6081};
  localparam logic [63:0] V_DATA [NVEC] = '{
    64'hA5A5_1234_5678_9ABC, 64'h0F0F_FFFF_FFFF_FFFF, 64'h8C8C_0000_0000_FFFF,
    64'hFFFF_0000_1111_2222, 64'h0000_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h0001_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000};
  localparam logic [15:0] V_EXP0 [NVEC] = '{
    16'hA5A5, 16'hAFAF, 16'h8C8C, 16'h8C8C, 16'h8C8C, 16'h8C8C,
    16'h8C8C, 16'h8C8C, 16'h0C8C, 16'h0C8C, 16'h8C8C, 16'h8C8C};
  localparam logic [15:0] V_EXP1 [NVEC] = '{
    16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000,
    16'h8000, 16'h8000, 16'h8000, 16'h8001, 16'h8001, 16'h0000};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_wr = 1'b0;
  logic              req_rd = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              v0, v1, irq0, irq1;
  logic [DATA_W-1:0] rd0, rd1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  misc_alias_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE(0)) u_misc_alias_reg (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(v0), .rsp_rdata(rd0), .irq_out(irq0));

  misc_alias_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE(1)) u_misc_alias_reg_clr (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(v1), .rsp_rdata(rd1), .irq_out(irq1));

  function automatic string tag_of(input logic [31:0] w);
    case (w)
      32'h4020, 32'h6080: return "R7";
      32'h4021:           return "R4";
      32'h6081:           return "R6";
      32'h4022, 32'h6082: return "R5";
      default:            return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0; req_wdata = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    req_rd = 1'b1; req_addr = a;
    @(negedge clk);
    req_rd = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 irq0", 64'(irq0), 64'h0);
    check("R10 irq1", 64'(irq1), 64'h0);
    check("R11 idle valid", 64'({v0, v1}), 64'h0);
    bus_read(32'h4020 << 3);
    check("R10 read0", rd0, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(V_WORD[i] << 3, V_DATA[i]);
      check({tag_of(V_WORD[i]), " R8 irq0"}, 64'(irq0), 64'(V_EXP0[i][15]));
      check({tag_of(V_WORD[i]), " R8 irq1"}, 64'(irq1), 64'(V_EXP1[i][15]));
      bus_read(32'h4020 << 3);
      check({tag_of(V_WORD[i]), " R2 R3 mode0"}, rd0, {V_EXP0[i], 48'h0});
      check("R9 R2 mode1 reads mode0 offset", rd1, 64'h0);
      bus_read(32'h6080 << 3);
      check({tag_of(V_WORD[i]), " R2 R3 mode1"}, rd1, {V_EXP1[i], 48'h0});
      check("R11 valid", 64'(v1), 64'h1);
    end

    // R1: low byte-address bits do not affect decode (OR alias, mode 0)
    bus_write((32'h4022 << 3) | 32'h3, 64'h0001_0000_0000_0000);
    bus_read((32'h4020 << 3) | 32'h7);
    check("R1 low addr bits", rd0, 64'h8C8D_0000_0000_0000);

    // R9: reading an alias offset returns zero
    bus_read(32'h4021 << 3);
    check("R9 alias read zero", rd0, 64'h0);
    check("R11 alias read valid", 64'(v0), 64'h1);

    // R11: read and write in the same cycle return the old value
    @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b1; req_addr = 32'h4020 << 3; req_wdata = 64'h1234_0000_0000_0000;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b0;
    check("R11 old value on collision", rd0, 64'h8C8D_0000_0000_0000);
    check("R8 irq falls", 64'(irq0), 64'h0);
    @(negedge clk);
    check("R11 valid one cycle", 64'(v0), 64'h0);
    bus_read(32'h4020 << 3);
    check("R7 new value", rd0, 64'h1234_0000_0000_0000);

    // R10: reset in mid-run
    bus_write(32'h4020 << 3, 64'hF000_0000_0000_0000);
    check("R8 irq rises", 64'(irq0), 64'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 irq after reset", 64'(irq0), 64'h0);
    bus_read(32'h4020 << 3);
    check("R10 value after reset", rd0, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule